// File: doc/BRIEF.md
# Modular-Exponentiation Engine Control Registers

This block is the register front end of a public-key exponentiation accelerator. A processor on a simple 32-bit bus sets up a job: it chooses who owns the operand memory and the load mode, the DMA source address and byte count, and the exponent and modulus bit lengths. It then launches the engine and the operand DMA together through one trigger write. The block turns that write into single-cycle start pulses, keeps a busy flag until the engine reports completion, latches the completion in an interrupt status register, and raises a level interrupt whenever an enabled status bit is set.

The operand memory is a small word array inside the block. It has a CPU window on the bus and a read port for the engine. Only the current owner sees the contents: the CPU window reads zero and drops writes while the engine owns the memory, and the engine port reads zero while the CPU owns it. The arithmetic datapath is outside the block. The bench stands in for it with a stub that returns a done pulse a fixed number of cycles after each engine start.

Top module: `mexp_ctrl_regs`

## Requirements
- R1: After reset the registers read as follows: trigger 0, DMA command 0x100 (CPU owns the memory, mode 0), source base 0, length 0x1800, key lengths 0, mask 0 and status 0. After reset busy_o, irq_o and both start pulses are low.
- R2: Trigger write starts a job.
  - The write goes to offset 0x000 with be_i[0] set, a nonzero value in bits [1:0], and the block idle.
  - On the next cycle the block gives a one-cycle eng_start_o if bit 0 is set and a one-cycle dma_start_o if bit 1 is set.
  - busy_o rises in the same cycle as the pulses.
  - The trigger register reads back the two bits that were written.
- R3: A nonzero trigger write while busy_o is high is ignored. It produces no pulse and does not change the trigger readback.
- R4: Writing zero to the trigger register clears its readback at any time. It does not change busy_o.
- R5: A done_i pulse clears busy_o on the next cycle and sets status bit 1.
- R6: Interrupt status at 0x3FC is write-one-to-clear and needs be_i[0]. A clear and a done_i in the same cycle leave bit 1 set.
- R7: The mask at 0x3F8, bits [1:0], is read/write. irq_o is high while any status bit that is also enabled in the mask is set.
- R8: DMA command at 0x048.
  - Bits [5:4] drive dma_mode_o; the value 3 is the operand-load mode.
  - Bit 8 drives opm_cpu_o: 1 means the CPU owns the memory, 0 means the engine owns it.
  - All other bits read zero.
- R9: Source base (0x04C), length (0x050) and key length (0x058) are 32-bit read/write registers with per-byte strobes. exp_bits_o comes from key-length bits [31:16] and mod_bits_o from bits [15:0].
- R10: Operand memory window.
  - The memory is OPM_DEPTH words at byte offset 0x800.
  - While the CPU owns the memory, CPU writes with byte strobes and reads work normally, and em_rdata_o reads 0.
  - While the engine owns the memory, CPU reads return 0, CPU writes are dropped, and em_rdata_o returns the addressed word.
- R11: Reads of unmapped offsets return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| be_i | input | 4 | Byte strobes for writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle (0 when not a read) |
| eng_start_o | output | 1 | Engine start pulse |
| dma_start_o | output | 1 | Operand DMA start pulse |
| busy_o | output | 1 | Job in progress |
| done_i | input | 1 | Engine completion pulse |
| irq_o | output | 1 | Level interrupt |
| dma_mode_o | output | 2 | DMA load mode field |
| opm_cpu_o | output | 1 | 1 = CPU owns operand memory |
| src_base_o | output | 32 | DMA source base address |
| xfer_len_o | output | 32 | DMA length in bytes |
| exp_bits_o | output | 16 | Exponent bit length |
| mod_bits_o | output | 16 | Modulus bit length |
| em_addr_i | input | OPM_AW | Engine operand memory word address |
| em_rdata_o | output | 32 | Engine operand memory read data |

## Verification
A wrong busy flag shows up within one cycle of the next trigger write, as a missing or extra start pulse. A stuck or lost status bit shows on irq_o in the cycle after done_i once the mask enables it. A wrong ownership bit shows as zero or non-zero read data on the very next window access from either side, and a dropped or leaked write shows at the next read-back. The reference model follows every register and output each clock, so a divergence is reported in the cycle it appears and not only at the end of a sequence.

// File: rtl/mexp_pkg.sv
package mexp_pkg;
  localparam logic [11:0] OFS_TRIG = 12'h000;
  localparam logic [11:0] OFS_DCMD = 12'h048;
  localparam logic [11:0] OFS_SRC  = 12'h04C;
  localparam logic [11:0] OFS_LEN  = 12'h050;
  localparam logic [11:0] OFS_KLEN = 12'h058;
  localparam logic [11:0] OFS_IMSK = 12'h3F8;
  localparam logic [11:0] OFS_ISTS = 12'h3FC;

  localparam int DONE_BIT = 1;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_TRIG, SEL_DCMD, SEL_SRC, SEL_LEN,
    SEL_KLEN, SEL_IMSK, SEL_ISTS, SEL_OPM
  } reg_sel_e;

  function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                           input logic [31:0] new_v,
                                           input logic [3:0]  be);
    logic [31:0] res;
    for (int b = 0; b < 4; b++)
      res[8*b +: 8] = be[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
    return res;
  endfunction
endpackage

// File: rtl/mexp_trig.sv
module mexp_trig (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] val_i,
  input  logic       done_i,
  output logic [1:0] trig_o,
  output logic       busy_o,
  output logic       eng_start_o,
  output logic       dma_start_o
);
  logic go, stop;
  logic [1:0] trig_q;
  logic busy_q, eng_q, dma_q;

  assign go   = wr_i && (val_i != 2'b00) && !busy_q;
  assign stop = wr_i && (val_i == 2'b00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= '0;
      busy_q <= 1'b0;
      eng_q  <= 1'b0;
      dma_q  <= 1'b0;
    end else begin
      eng_q <= go && val_i[0];
      dma_q <= go && val_i[1];
      if (go)        trig_q <= val_i;
      else if (stop) trig_q <= '0;
      if (go)          busy_q <= 1'b1;
      else if (done_i) busy_q <= 1'b0;
    end
  end

  assign trig_o      = trig_q;
  assign busy_o      = busy_q;
  assign eng_start_o = eng_q;
  assign dma_start_o = dma_q;
endmodule

// File: rtl/mexp_cfg.sv
module mexp_cfg
  import mexp_pkg::*;
#(
  parameter int          IRQ_W   = 2,
  parameter logic [31:0] LEN_RST = 32'h0000_1800
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  reg_sel_e         sel_i,
  input  logic [3:0]       be_i,
  input  logic [31:0]      wdata_i,
  output logic [1:0]       mode_o,
  output logic             own_cpu_o,
  output logic [31:0]      src_o,
  output logic [31:0]      len_o,
  output logic [31:0]      klen_o,
  output logic [IRQ_W-1:0] imsk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o    <= 2'b00;
      own_cpu_o <= 1'b1;
      src_o     <= '0;
      len_o     <= LEN_RST;
      klen_o    <= '0;
      imsk_o    <= '0;
    end else if (wr_i) begin
      unique case (sel_i)
        SEL_DCMD: begin
          if (be_i[0]) mode_o    <= wdata_i[5:4];
          if (be_i[1]) own_cpu_o <= wdata_i[8];
        end
        SEL_SRC:  src_o  <= be_merge(src_o, wdata_i, be_i);
        SEL_LEN:  len_o  <= be_merge(len_o, wdata_i, be_i);
        SEL_KLEN: klen_o <= be_merge(klen_o, wdata_i, be_i);
        SEL_IMSK: if (be_i[0]) imsk_o <= wdata_i[IRQ_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mexp_irq.sv
module mexp_irq
  import mexp_pkg::*;
#(
  parameter int IRQ_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_wr_i,
  input  logic [IRQ_W-1:0] clr_i,
  input  logic             done_i,
  input  logic [IRQ_W-1:0] imsk_i,
  output logic [IRQ_W-1:0] sts_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] set_v, clr_v;

  always_comb begin
    set_v = '0;
    set_v[DONE_BIT] = done_i;
    clr_v = clr_wr_i ? clr_i : '0;
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_o <= '0;
    else         sts_o <= (sts_o & ~clr_v) | set_v;
  end

  assign irq_o = |(sts_o & imsk_i);
endmodule

// File: rtl/mexp_opmem.sv
module mexp_opmem
  import mexp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          own_cpu_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [3:0]    be_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   cpu_rdata_o,
  input  logic [AW-1:0] em_addr_i,
  output logic [31:0]   em_rdata_o
);
  logic [31:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < DEPTH; r++) mem_q[r] <= '0;
    end else if (cpu_we_i && own_cpu_i) begin
      mem_q[cpu_addr_i] <= be_merge(mem_q[cpu_addr_i], wdata_i, be_i);
    end
  end

  assign cpu_rdata_o = own_cpu_i ? mem_q[cpu_addr_i] : '0;
  assign em_rdata_o  = own_cpu_i ? '0 : mem_q[em_addr_i];
endmodule

// File: rtl/mexp_ctrl_regs.sv
module mexp_ctrl_regs
  import mexp_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          IRQ_W     = 2,
  parameter int          OPM_DEPTH = 16,
  parameter logic [31:0] LEN_RST   = 32'h0000_1800,
  localparam int         OPM_AW    = $clog2(OPM_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              eng_start_o,
  output logic              dma_start_o,
  output logic              busy_o,
  input  logic              done_i,
  output logic              irq_o,
  output logic [1:0]        dma_mode_o,
  output logic              opm_cpu_o,
  output logic [31:0]       src_base_o,
  output logic [31:0]       xfer_len_o,
  output logic [15:0]       exp_bits_o,
  output logic [15:0]       mod_bits_o,
  input  logic [OPM_AW-1:0] em_addr_i,
  output logic [31:0]       em_rdata_o
);
  reg_sel_e         sel;
  logic             wr, opm_hit;
  logic [1:0]       trig;
  logic [31:0]      klen, opm_rdata, rd_mux;
  logic [IRQ_W-1:0] imsk, sts;
  logic [11:0]      ofs;

  assign wr  = req_i && we_i;
  assign ofs = 12'(addr_i);
  assign opm_hit = addr_i[ADDR_W-1] && (addr_i[ADDR_W-2:OPM_AW+2] == '0)
                   && (addr_i[1:0] == 2'b00);

  always_comb begin
    sel = SEL_NONE;
    if (opm_hit) sel = SEL_OPM;
    else if (!addr_i[ADDR_W-1]) begin
      unique case (ofs)
        OFS_TRIG: sel = SEL_TRIG;
        OFS_DCMD: sel = SEL_DCMD;
        OFS_SRC:  sel = SEL_SRC;
        OFS_LEN:  sel = SEL_LEN;
        OFS_KLEN: sel = SEL_KLEN;
        OFS_IMSK: sel = SEL_IMSK;
        OFS_ISTS: sel = SEL_ISTS;
        default:  sel = SEL_NONE;
      endcase
    end
  end

  mexp_trig i_trig (
    .clk_i, .rst_ni,
    .wr_i        (wr && sel == SEL_TRIG && be_i[0]),
    .val_i       (wdata_i[1:0]),
    .done_i,
    .trig_o      (trig),
    .busy_o,
    .eng_start_o,
    .dma_start_o
  );

  mexp_cfg #(.IRQ_W(IRQ_W), .LEN_RST(LEN_RST)) i_cfg (
    .clk_i, .rst_ni,
    .wr_i      (wr),
    .sel_i     (sel),
    .be_i,
    .wdata_i,
    .mode_o    (dma_mode_o),
    .own_cpu_o (opm_cpu_o),
    .src_o     (src_base_o),
    .len_o     (xfer_len_o),
    .klen_o    (klen),
    .imsk_o    (imsk)
  );

  mexp_irq #(.IRQ_W(IRQ_W)) i_irq (
    .clk_i, .rst_ni,
    .clr_wr_i (wr && sel == SEL_ISTS && be_i[0]),
    .clr_i    (wdata_i[IRQ_W-1:0]),
    .done_i,
    .imsk_i   (imsk),
    .sts_o    (sts),
    .irq_o
  );

  mexp_opmem #(.DEPTH(OPM_DEPTH)) i_opmem (
    .clk_i, .rst_ni,
    .own_cpu_i   (opm_cpu_o),
    .cpu_we_i    (wr && sel == SEL_OPM),
    .cpu_addr_i  (addr_i[OPM_AW+1:2]),
    .be_i,
    .wdata_i,
    .cpu_rdata_o (opm_rdata),
    .em_addr_i,
    .em_rdata_o
  );

  assign exp_bits_o = klen[31:16];
  assign mod_bits_o = klen[15:0];

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_TRIG: rd_mux = {30'b0, trig};
      SEL_DCMD: rd_mux = {23'b0, opm_cpu_o, 2'b0, dma_mode_o, 4'b0};
      SEL_SRC:  rd_mux = src_base_o;
      SEL_LEN:  rd_mux = xfer_len_o;
      SEL_KLEN: rd_mux = klen;
      SEL_IMSK: rd_mux = 32'(imsk);
      SEL_ISTS: rd_mux = 32'(sts);
      SEL_OPM:  rd_mux = opm_rdata;
      default:  rd_mux = '0;
    endcase
  end

  assign rdata_o = (req_i && !we_i) ? rd_mux : '0;
endmodule

// File: rtl/mexp_ctrl_chk.sv
module mexp_ctrl_chk #(
  parameter int ADDR_W = 12,
  parameter int IRQ_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       rdata_o,
  input logic              eng_start_o,
  input logic              dma_start_o,
  input logic              busy_o,
  input logic              done_i,
  input logic              irq_o,
  input logic              opm_cpu_o,
  input logic [IRQ_W-1:0]  imsk_i
);
  assert_pulse_once_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);

  assert_busy_with_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_start_o || dma_start_o) |-> busy_o);

  assert_no_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !(eng_start_o || dma_start_o));

  assert_done_releases_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (!busy_o || eng_start_o || dma_start_o));

  assert_irq_follows_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && imsk_i[1]) |=> irq_o);

  assert_opm_hidden_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[ADDR_W-1] && !opm_cpu_o) |-> (rdata_o == '0));
endmodule

bind mexp_ctrl_regs mexp_ctrl_chk #(.ADDR_W(ADDR_W), .IRQ_W(IRQ_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .rdata_o     (rdata_o),
  .eng_start_o (eng_start_o),
  .dma_start_o (dma_start_o),
  .busy_o      (busy_o),
  .done_i      (done_i),
  .irq_o       (irq_o),
  .opm_cpu_o   (opm_cpu_o),
  .imsk_i      (imsk)
);

// File: tb/test_mexp_ctrl_regs.sv
`timescale 1ns/1ps
module test_mexp_ctrl_regs;
  localparam int LAT = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0;
  logic [11:0] addr = 0;
  logic [3:0]  be = 0;
  logic [31:0] wdata = 0, rdata;
  logic eng_start, dma_start, busy, irq, opm_cpu;
  logic [1:0] dma_mode;
  logic [31:0] src_base, xfer_len, em_rdata;
  logic [15:0] exp_bits, mod_bits;
  logic [3:0] em_addr = 0;
  logic stub_done = 0, man_done = 0, stub_en = 1;
  logic done;
  int stub_cnt = 0;
  int total = 0, bad = 0;
  bit finished = 0;

  assign done = stub_done | man_done;
  always #2.5 clk = ~clk;

  mexp_ctrl_regs i_mexp_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .eng_start_o(eng_start),
    .dma_start_o(dma_start), .busy_o(busy), .done_i(done), .irq_o(irq),
    .dma_mode_o(dma_mode), .opm_cpu_o(opm_cpu), .src_base_o(src_base),
    .xfer_len_o(xfer_len), .exp_bits_o(exp_bits), .mod_bits_o(mod_bits),
    .em_addr_i(em_addr), .em_rdata_o(em_rdata)
  );

  // reference model
  logic [1:0]  m_trig, m_mode, m_imsk, m_sts;
  logic        m_busy, m_eng, m_dma, m_own;
  logic [31:0] m_src, m_len, m_klen;
  logic [31:0] m_mem [16];

  function automatic logic [31:0] mrg(logic [31:0] o, logic [31:0] n, logic [3:0] b);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = b[k] ? n[8*k +: 8] : o[8*k +: 8];
    return r;
  endfunction

  function automatic bit win(logic [11:0] a);
    return a[11] && a[10:6] == 0 && a[1:0] == 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_trig = 0; m_busy = 0; m_eng = 0; m_dma = 0; m_mode = 0; m_own = 1;
      m_src = 0; m_len = 32'h1800; m_klen = 0; m_imsk = 0; m_sts = 0;
      for (int i = 0; i < 16; i++) m_mem[i] = 0;
    end else begin
      bit w, go, stop;
      logic [1:0] clr;
      w    = req && we;
      go   = w && addr == 12'h000 && be[0] && wdata[1:0] != 0 && !m_busy;
      stop = w && addr == 12'h000 && be[0] && wdata[1:0] == 0;
      m_eng = go && wdata[0];
      m_dma = go && wdata[1];
      if (go) m_trig = wdata[1:0]; else if (stop) m_trig = 0;
      if (go) m_busy = 1; else if (done) m_busy = 0;
      clr = (w && addr == 12'h3FC && be[0]) ? wdata[1:0] : 2'b00;
      m_sts = (m_sts & ~clr) | (done ? 2'b10 : 2'b00);
      if (w && win(addr) && m_own) m_mem[addr[5:2]] = mrg(m_mem[addr[5:2]], wdata, be);
      if (w) begin
        case (addr)
          12'h048: begin
            if (be[0]) m_mode = wdata[5:4];
            if (be[1]) m_own = wdata[8];
          end
          12'h04C: m_src  = mrg(m_src, wdata, be);
          12'h050: m_len  = mrg(m_len, wdata, be);
          12'h058: m_klen = mrg(m_klen, wdata, be);
          12'h3F8: if (be[0]) m_imsk = wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_read(logic [11:0] a);
    if (win(a)) return m_own ? m_mem[a[5:2]] : 0;
    case (a)
      12'h000: return {30'b0, m_trig};
      12'h048: return {23'b0, m_own, 2'b0, m_mode, 4'b0};
      12'h04C: return m_src;
      12'h050: return m_len;
      12'h058: return m_klen;
      12'h3F8: return {30'b0, m_imsk};
      12'h3FC: return {30'b0, m_sts};
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // engine stub: done a fixed latency after each engine start
  always @(negedge clk) begin
    if (stub_done) stub_done = 0;
    if (stub_cnt > 0) begin
      stub_cnt--;
      if (stub_cnt == 0) stub_done = 1;
    end
    if (eng_start && stub_en) stub_cnt = LAT;
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2 eng_start", eng_start, m_eng);
      check("R2 dma_start", dma_start, m_dma);
      check("R5 busy", busy, m_busy);
      check("R7 irq", irq, |(m_sts & m_imsk));
      check("R8 mode/own", {dma_mode, opm_cpu}, {m_mode, m_own});
      check("R9 src", src_base, m_src);
      check("R9 len", xfer_len, m_len);
      check("R9 key bits", {exp_bits, mod_bits}, m_klen);
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [3:0] b);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d; be = b;
    @(negedge clk);
    req = 0; we = 0; be = 0;
  endtask

  task automatic rd(logic [11:0] a, string tag);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1 check(tag, rdata, m_read(a));
    req = 0;
  endtask

  task automatic rd_exp(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1 check(tag, rdata, exp);
    req = 0;
  endtask

  task automatic em_chk(logic [3:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    em_addr = a;
    #1 check(tag, em_rdata, exp);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd_exp(12'h000, 32'h0, "R1 trig");
    rd_exp(12'h048, 32'h100, "R1 dcmd");
    rd_exp(12'h04C, 32'h0, "R1 src");
    rd_exp(12'h050, 32'h1800, "R1 len");
    rd_exp(12'h058, 32'h0, "R1 klen");
    rd_exp(12'h3F8, 32'h0, "R1 imsk");
    rd_exp(12'h3FC, 32'h0, "R1 sts");
    check("R1 busy/irq", {busy, irq, eng_start, dma_start}, 4'b0);

    // R9 byte strobes and key length split
    wr(12'h058, 32'h0011_0800, 4'hF);
    rd_exp(12'h058, 32'h0011_0800, "R9 klen");
    check("R9 exp/mod", {exp_bits, mod_bits}, 32'h0011_0800);
    wr(12'h04C, 32'hDEAD_BEEF, 4'hF);
    wr(12'h04C, 32'h1234_5678, 4'b0101);
    rd_exp(12'h04C, 32'hDE34_BE78, "R9 src strobes");
    wr(12'h050, 32'h0000_0040, 4'b0001);
    rd_exp(12'h050, 32'h0000_1840, "R9 len strobes");

    // R10 CPU-owned window
    for (int i = 0; i < 4; i++) wr(12'h800 + 12'(4*i), 32'hA000_0000 + i, 4'hF);
    wr(12'h804, 32'hFFFF_FFFF, 4'b1000);
    rd_exp(12'h804, 32'hFF00_0001, "R10 cpu rw");
    em_chk(4'd1, 32'h0, "R10 engine blank");

    // R8 command register
    wr(12'h048, 32'hFFFF_FFFF, 4'hF);
    rd_exp(12'h048, 32'h130, "R8 dcmd bits");
    wr(12'h048, 32'h0000_0030, 4'hF);
    rd_exp(12'h048, 32'h030, "R8 engine owns");
    check("R8 mode out", dma_mode, 2'b11);

    // R10 engine-owned window
    rd_exp(12'h800, 32'h0, "R10 cpu blank");
    wr(12'h808, 32'h5555_5555, 4'hF);
    em_chk(4'd2, 32'hA000_0002, "R10 engine read");
    wr(12'h048, 32'h0000_0100, 4'b0010);
    rd_exp(12'h808, 32'hA000_0002, "R10 write dropped");

    // R11 unmapped
    wr(12'h100, 32'hFFFF_FFFF, 4'hF);
    rd_exp(12'h100, 32'h0, "R11 unmapped");
    rd_exp(12'h840, 32'h0, "R11 past window");
    rd(12'h04C, "R11 no side effect");

    // R2..R5, R7
    wr(12'h3F8, 32'h2, 4'h1);
    wr(12'h000, 32'h3, 4'h0);
    rd_exp(12'h000, 32'h0, "R2 no strobe");
    wr(12'h000, 32'h3, 4'h1);
    check("R2 busy set", busy, 1'b1);
    wr(12'h000, 32'h1, 4'h1);
    rd_exp(12'h000, 32'h3, "R3 ignored");
    wr(12'h000, 32'h0, 4'h1);
    rd_exp(12'h000, 32'h0, "R4 cleared");
    check("R4 still busy", busy, 1'b1);
    repeat (LAT + 2) @(negedge clk);
    check("R5 idle", busy, 1'b0);
    rd_exp(12'h3FC, 32'h2, "R5 status");
    check("R7 irq high", irq, 1'b1);

    // R6 W1C
    wr(12'h3FC, 32'h2, 4'h2);
    rd_exp(12'h3FC, 32'h2, "R6 no strobe");
    wr(12'h3FC, 32'h2, 4'h1);
    rd_exp(12'h3FC, 32'h0, "R6 cleared");
    check("R7 irq low", irq, 1'b0);
    stub_en = 0;
    @(negedge clk);
    req = 1; we = 1; addr = 12'h3FC; wdata = 32'h2; be = 4'h1; man_done = 1;
    @(negedge clk);
    req = 0; we = 0; be = 0; man_done = 0;
    rd_exp(12'h3FC, 32'h2, "R6 set wins");

    // DMA-only start, masked interrupt
    wr(12'h3F8, 32'h0, 4'h1);
    wr(12'h000, 32'h2, 4'h1);
    rd_exp(12'h000, 32'h2, "R2 dma only");
    repeat (3) @(negedge clk);
    man_done = 1;
    @(negedge clk);
    man_done = 0;
    @(negedge clk);
    check("R5 busy clear", busy, 1'b0);
    check("R7 masked", irq, 1'b0);
    stub_en = 1;
    wr(12'h000, 32'h1, 4'h1);
    repeat (LAT + 2) @(negedge clk);
    rd(12'h3FC, "R5 second job");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule